// File: doc/BRIEF.md
# Register Rename Unit with Branch Checkpoints

This block renames one decoded instruction per cycle onto a merged physical register file. Each logical source specifier is translated through a mapping table to the physical register that currently holds its value. A logical destination receives a fresh physical register taken from a pool of unused registers, and the mapping table is updated so that later instructions read the new name. The previous physical name of that destination is reported with the instruction, so that retirement can hand it back to the pool.

Control flow is speculative. Each predicted branch that passes through rename claims one of a small number of branch slots and saves a snapshot of the mapping table together with the pool's read position. Every renamed instruction carries a bit vector naming the unresolved branches it depends on. A correct resolution releases the slot. A misprediction reloads the snapshot, rewinds the pool so that every register handed out after the branch becomes free again, and discards all branches younger than the one that failed.

Top module: `rename_unit`

## Requirements
- R1: After reset logical register i maps to physical register i, and destinations receive physical registers NUM_LOG, NUM_LOG+1, ... in ascending order (32, 33, ... with default parameters).
- R2: `out_psrc1` and `out_psrc2` give the current mapping of the source specifiers; an instruction's own destination does not affect its own sources, and later instructions see the new mapping.
- R3: `out_old_pdst` gives the mapping the destination held before this instruction, and `out_pdst` differs from it.
- R4: An instruction with a destination stalls (`ren_ready` and `out_valid` low) while the pool is empty; an instruction without a destination still proceeds.
- R5: A register returned through `cmt_valid`/`cmt_old_pdst` joins the back of the pool, so registers are handed out again in the order they were returned.
- R6: Up to NUM_BR (4) branches may be unresolved; a branch arriving while all slots are taken stalls. A branch is given the lowest-numbered free slot on `out_br_tag`.
- R7: `out_mask` has bit k set exactly when slot k holds an unresolved branch older than the instruction; a branch's own bit is clear in its mask, and a slot resolved correctly in the same cycle is already clear.
- R8: A correct resolution (`rsv_valid` with `rsv_mispredict` low) frees the slot, which the next branch can claim.
- R9: A misprediction restores the mapping table to its state just after the failing branch was renamed, and the next destination receives the first register that was handed out after that branch.
- R10: A misprediction discards the failing branch and every younger branch from the mask, and keeps the older unresolved branches.
- R11: In a cycle with a misprediction of an unresolved branch, rename is blocked: `ren_ready` and `out_valid` are low.
- R12: A resolution or misprediction naming a slot that holds no unresolved branch has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ren_valid | input | 1 | An instruction is offered for rename |
| ren_src1 | input | 5 | First logical source |
| ren_src2 | input | 5 | Second logical source |
| ren_has_dst | input | 1 | Instruction writes a logical destination |
| ren_dst | input | 5 | Logical destination |
| ren_is_branch | input | 1 | Instruction is a predicted branch |
| ren_ready | output | 1 | Offered instruction can be renamed this cycle |
| out_valid | output | 1 | Instruction renamed this cycle |
| out_psrc1 | output | 6 | Physical register for the first source |
| out_psrc2 | output | 6 | Physical register for the second source |
| out_pdst | output | 6 | Newly allocated physical destination (0 when none) |
| out_old_pdst | output | 6 | Previous physical mapping of the destination |
| out_mask | output | 4 | Unresolved older branches the instruction depends on |
| out_br_tag | output | 2 | Slot given to a renamed branch |
| rsv_valid | input | 1 | A branch outcome is reported |
| rsv_tag | input | 2 | Slot of the resolved branch |
| rsv_mispredict | input | 1 | The branch was mispredicted |
| cmt_valid | input | 1 | A retiring instruction frees a register |
| cmt_old_pdst | input | 6 | Physical register released at retirement |

## Verification
The checker watches, on every cycle, that no destination is handed out from an empty pool, that a new destination never equals the mapping it replaces, that a branch never takes a slot already in use, that the outgoing mask names only unresolved slots, that a misprediction blocks rename in its cycle, and that a correct resolution frees its slot on the next edge. Whether a restored mapping and rewound pool match what existed just after the failing branch, the ordering of returned registers, and which branches survive a misprediction depend on histories of several instructions, so only the bench's scenarios with their computed register numbers can show them.

// File: rtl/rn_pkg.sv
package rn_pkg;
    parameter int unsigned RN_LOG_REGS  = 32;
    parameter int unsigned RN_PHYS_REGS = 64;
    parameter int unsigned RN_BRANCHES  = 4;

    typedef enum logic [1:0] {
        RSV_NONE = 2'd0,
        RSV_OK   = 2'd1,
        RSV_MISS = 2'd2
    } rsv_kind_e;
endpackage

// File: rtl/rn_free_list.sv
module rn_free_list #(
    parameter int unsigned NUM_LOG  = rn_pkg::RN_LOG_REGS,
    parameter int unsigned NUM_PHYS = rn_pkg::RN_PHYS_REGS,
    localparam int unsigned PW      = $clog2(NUM_PHYS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pop_i,
    input  logic          push_i,
    input  logic [PW-1:0] push_reg_i,
    input  logic          restore_i,
    input  logic [PW:0]   restore_head_i,
    output logic [PW-1:0] head_reg_o,
    output logic [PW:0]   head_next_o,
    output logic [PW:0]   count_o
);
    typedef struct packed {
        logic [NUM_PHYS-1:0][PW-1:0] slot;
        logic [PW:0]                 head;
        logic [PW:0]                 tail;
    } fl_state_t;

    function automatic fl_state_t init_state();
        fl_state_t s;
        for (int i = 0; i < NUM_PHYS; i++) begin
            s.slot[i] = (i < NUM_PHYS - NUM_LOG) ? PW'(NUM_LOG + i) : '0;
        end
        s.head = '0;
        s.tail = (PW+1)'(NUM_PHYS - NUM_LOG);
        return s;
    endfunction

    fl_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (pop_i) begin
            st_d.head = st_q.head + (PW+1)'(1);
        end
        if (restore_i) begin
            st_d.head = restore_head_i;
        end
        if (push_i) begin
            st_d.slot[st_q.tail[PW-1:0]] = push_reg_i;
            st_d.tail = st_q.tail + (PW+1)'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= init_state();
        end else begin
            st_q <= st_d;
        end
    end

    assign head_reg_o  = st_q.slot[st_q.head[PW-1:0]];
    assign head_next_o = st_q.head + (PW+1)'(pop_i);
    assign count_o     = st_q.tail - st_q.head;
endmodule

// File: rtl/rn_map_table.sv
module rn_map_table #(
    parameter int unsigned NUM_LOG  = rn_pkg::RN_LOG_REGS,
    parameter int unsigned NUM_PHYS = rn_pkg::RN_PHYS_REGS,
    parameter int unsigned NUM_BR   = rn_pkg::RN_BRANCHES,
    localparam int unsigned LW      = $clog2(NUM_LOG),
    localparam int unsigned PW      = $clog2(NUM_PHYS),
    localparam int unsigned BW      = $clog2(NUM_BR)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [LW-1:0] rd_a_i,
    input  logic [LW-1:0] rd_b_i,
    input  logic [LW-1:0] rd_d_i,
    output logic [PW-1:0] rd_a_o,
    output logic [PW-1:0] rd_b_o,
    output logic [PW-1:0] rd_d_o,
    input  logic          wr_i,
    input  logic [LW-1:0] wr_log_i,
    input  logic [PW-1:0] wr_phys_i,
    input  logic          save_i,
    input  logic [BW-1:0] save_slot_i,
    input  logic          restore_i,
    input  logic [BW-1:0] restore_slot_i
);
    typedef logic [NUM_LOG-1:0][PW-1:0] map_t;

    typedef struct packed {
        map_t                   map;
        logic [NUM_BR-1:0][NUM_LOG*PW-1:0] ckpt;
    } mt_state_t;

    function automatic mt_state_t init_state();
        mt_state_t s;
        for (int i = 0; i < NUM_LOG; i++) begin
            s.map[i] = PW'(i);
        end
        for (int b = 0; b < NUM_BR; b++) begin
            s.ckpt[b] = s.map;
        end
        return s;
    endfunction

    mt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (restore_i) begin
            st_d.map = st_q.ckpt[restore_slot_i];
        end else if (wr_i) begin
            st_d.map[wr_log_i] = wr_phys_i;
        end
        if (save_i) begin
            st_d.ckpt[save_slot_i] = st_d.map;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= init_state();
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_a_o = st_q.map[rd_a_i];
    assign rd_b_o = st_q.map[rd_b_i];
    assign rd_d_o = st_q.map[rd_d_i];
endmodule

// File: rtl/rn_branch_ctl.sv
module rn_branch_ctl #(
    parameter int unsigned NUM_BR = rn_pkg::RN_BRANCHES,
    parameter int unsigned PTRW   = 7,
    localparam int unsigned BW    = $clog2(NUM_BR)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_i,
    input  logic [PTRW-1:0]   head_i,
    input  logic              rsv_valid_i,
    input  logic [BW-1:0]     rsv_tag_i,
    input  logic              rsv_miss_i,
    output logic [BW-1:0]     slot_o,
    output logic [NUM_BR-1:0] live_mask_o,
    output logic [NUM_BR-1:0] pending_o,
    output logic              restore_o,
    output logic [PTRW-1:0]   restore_head_o
);
    import rn_pkg::*;

    typedef struct packed {
        logic [NUM_BR-1:0]             pending;
        logic [NUM_BR-1:0][NUM_BR-1:0] parent;
        logic [NUM_BR-1:0][PTRW-1:0]   head;
    } br_state_t;

    br_state_t  st_d, st_q;
    rsv_kind_e  kind;
    logic [NUM_BR-1:0] tag_bit;

    always_comb begin
        tag_bit = '0;
        tag_bit[rsv_tag_i] = 1'b1;
        if (!rsv_valid_i || !st_q.pending[rsv_tag_i]) begin
            kind = RSV_NONE;
        end else if (rsv_miss_i) begin
            kind = RSV_MISS;
        end else begin
            kind = RSV_OK;
        end
    end

    always_comb begin
        slot_o = '0;
        for (int i = NUM_BR - 1; i >= 0; i--) begin
            if (!st_q.pending[i]) begin
                slot_o = BW'(i);
            end
        end
    end

    assign live_mask_o    = st_q.pending & ~((kind == RSV_OK) ? tag_bit : '0);
    assign pending_o      = st_q.pending;
    assign restore_o      = (kind == RSV_MISS);
    assign restore_head_o = st_q.head[rsv_tag_i];

    always_comb begin
        st_d = st_q;
        case (kind)
            RSV_OK: begin
                st_d.pending = st_q.pending & ~tag_bit;
                for (int i = 0; i < NUM_BR; i++) begin
                    st_d.parent[i] = st_q.parent[i] & ~tag_bit;
                end
            end
            RSV_MISS: begin
                st_d.pending = st_q.pending & st_q.parent[rsv_tag_i];
            end
            default: ;
        endcase
        if (alloc_i) begin
            st_d.pending[slot_o] = 1'b1;
            st_d.parent[slot_o]  = live_mask_o;
            st_d.head[slot_o]    = head_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/rename_unit.sv
module rename_unit #(
    parameter int unsigned NUM_LOG  = rn_pkg::RN_LOG_REGS,
    parameter int unsigned NUM_PHYS = rn_pkg::RN_PHYS_REGS,
    parameter int unsigned NUM_BR   = rn_pkg::RN_BRANCHES,
    localparam int unsigned LW      = $clog2(NUM_LOG),
    localparam int unsigned PW      = $clog2(NUM_PHYS),
    localparam int unsigned BW      = $clog2(NUM_BR)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ren_valid,
    input  logic [LW-1:0]     ren_src1,
    input  logic [LW-1:0]     ren_src2,
    input  logic              ren_has_dst,
    input  logic [LW-1:0]     ren_dst,
    input  logic              ren_is_branch,
    output logic              ren_ready,
    output logic              out_valid,
    output logic [PW-1:0]     out_psrc1,
    output logic [PW-1:0]     out_psrc2,
    output logic [PW-1:0]     out_pdst,
    output logic [PW-1:0]     out_old_pdst,
    output logic [NUM_BR-1:0] out_mask,
    output logic [BW-1:0]     out_br_tag,
    input  logic              rsv_valid,
    input  logic [BW-1:0]     rsv_tag,
    input  logic              rsv_mispredict,
    input  logic              cmt_valid,
    input  logic [PW-1:0]     cmt_old_pdst
);
    logic          fire;
    logic          do_alloc;
    logic          do_branch;
    logic          squash;
    logic [PW-1:0] head_reg;
    logic [PW:0]   head_next;
    logic [PW:0]   restore_head;
    logic [PW:0]   fl_count;
    logic [BW-1:0] br_slot;
    logic [NUM_BR-1:0] br_live;
    logic [NUM_BR-1:0] br_pending;

    assign ren_ready = !squash
                    && (!ren_has_dst || (fl_count != '0))
                    && (!ren_is_branch || !(&br_pending));
    assign fire      = ren_valid && ren_ready;
    assign do_alloc  = fire && ren_has_dst;
    assign do_branch = fire && ren_is_branch;

    rn_free_list #(.NUM_LOG(NUM_LOG), .NUM_PHYS(NUM_PHYS)) u_free (
        .clk            (clk),
        .rst_n          (rst_n),
        .pop_i          (do_alloc),
        .push_i         (cmt_valid),
        .push_reg_i     (cmt_old_pdst),
        .restore_i      (squash),
        .restore_head_i (restore_head),
        .head_reg_o     (head_reg),
        .head_next_o    (head_next),
        .count_o        (fl_count)
    );

    rn_map_table #(.NUM_LOG(NUM_LOG), .NUM_PHYS(NUM_PHYS), .NUM_BR(NUM_BR)) u_map (
        .clk            (clk),
        .rst_n          (rst_n),
        .rd_a_i         (ren_src1),
        .rd_b_i         (ren_src2),
        .rd_d_i         (ren_dst),
        .rd_a_o         (out_psrc1),
        .rd_b_o         (out_psrc2),
        .rd_d_o         (out_old_pdst),
        .wr_i           (do_alloc),
        .wr_log_i       (ren_dst),
        .wr_phys_i      (head_reg),
        .save_i         (do_branch),
        .save_slot_i    (br_slot),
        .restore_i      (squash),
        .restore_slot_i (rsv_tag)
    );

    rn_branch_ctl #(.NUM_BR(NUM_BR), .PTRW(PW + 1)) u_br (
        .clk            (clk),
        .rst_n          (rst_n),
        .alloc_i        (do_branch),
        .head_i         (head_next),
        .rsv_valid_i    (rsv_valid),
        .rsv_tag_i      (rsv_tag),
        .rsv_miss_i     (rsv_mispredict),
        .slot_o         (br_slot),
        .live_mask_o    (br_live),
        .pending_o      (br_pending),
        .restore_o      (squash),
        .restore_head_o (restore_head)
    );

    assign out_valid  = fire;
    assign out_pdst   = ren_has_dst ? head_reg : '0;
    assign out_mask   = br_live;
    assign out_br_tag = ren_is_branch ? br_slot : '0;
endmodule

// File: rtl/rn_checker.sv
module rn_checker #(
    parameter int unsigned NUM_PHYS = rn_pkg::RN_PHYS_REGS,
    parameter int unsigned NUM_BR   = rn_pkg::RN_BRANCHES,
    localparam int unsigned PW      = $clog2(NUM_PHYS),
    localparam int unsigned BW      = $clog2(NUM_BR)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ren_has_dst,
    input logic              ren_is_branch,
    input logic              out_valid,
    input logic [PW-1:0]     out_pdst,
    input logic [PW-1:0]     out_old_pdst,
    input logic [NUM_BR-1:0] out_mask,
    input logic [BW-1:0]     out_br_tag,
    input logic              rsv_valid,
    input logic [BW-1:0]     rsv_tag,
    input logic              rsv_mispredict,
    input logic [PW:0]       fl_count,
    input logic [NUM_BR-1:0] br_pending
);
    p_alloc_needs_free_r4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && ren_has_dst |-> fl_count != '0);

    p_fresh_dst_r3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && ren_has_dst |-> out_pdst != out_old_pdst);

    p_pool_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fl_count <= (PW+1)'(NUM_PHYS));

    p_slot_unused_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && ren_is_branch |-> !br_pending[out_br_tag]);

    p_mask_live_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_mask & ~br_pending) == '0);

    p_resolve_frees_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rsv_valid && !rsv_mispredict && br_pending[rsv_tag] |=> !br_pending[$past(rsv_tag)]);

    p_squash_blocks_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rsv_valid && rsv_mispredict && br_pending[rsv_tag] |-> !out_valid);
endmodule

bind rename_unit rn_checker #(.NUM_PHYS(NUM_PHYS), .NUM_BR(NUM_BR)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .ren_has_dst    (ren_has_dst),
    .ren_is_branch  (ren_is_branch),
    .out_valid      (out_valid),
    .out_pdst       (out_pdst),
    .out_old_pdst   (out_old_pdst),
    .out_mask       (out_mask),
    .out_br_tag     (out_br_tag),
    .rsv_valid      (rsv_valid),
    .rsv_tag        (rsv_tag),
    .rsv_mispredict (rsv_mispredict),
    .fl_count       (fl_count),
    .br_pending     (br_pending)
);

// File: tb/tb_rename_unit.sv
module tb_rename_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ren_valid = 1'b0;
    logic [4:0] ren_src1 = '0, ren_src2 = '0, ren_dst = '0;
    logic       ren_has_dst = 1'b0, ren_is_branch = 1'b0;
    logic       ren_ready, out_valid;
    logic [5:0] out_psrc1, out_psrc2, out_pdst, out_old_pdst;
    logic [3:0] out_mask;
    logic [1:0] out_br_tag;
    logic       rsv_valid = 1'b0, rsv_mispredict = 1'b0;
    logic [1:0] rsv_tag = '0;
    logic       cmt_valid = 1'b0;
    logic [5:0] cmt_old_pdst = '0;

    int checks = 0;
    int errs   = 0;

    always #4 clk = ~clk;

    rename_unit dut (.*);

    // {src1, src2, has_dst, dst, exp_psrc1, exp_psrc2, exp_pdst, exp_old}
    localparam logic [39:0] VEC [6] = '{
        {5'd1,  5'd2, 1'b1, 5'd3,  6'd1,  6'd2,  6'd32, 6'd3},
        {5'd3,  5'd4, 1'b1, 5'd3,  6'd32, 6'd4,  6'd33, 6'd32},
        {5'd3,  5'd3, 1'b1, 5'd5,  6'd33, 6'd33, 6'd34, 6'd5},
        {5'd5,  5'd0, 1'b0, 5'd0,  6'd34, 6'd0,  6'd0,  6'd0},
        {5'd31, 5'd5, 1'b1, 5'd31, 6'd31, 6'd34, 6'd35, 6'd31},
        {5'd31, 5'd3, 1'b1, 5'd0,  6'd35, 6'd33, 6'd36, 6'd0}
    };

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step(input logic v, input int s1, input int s2, input logic hd,
                        input int d, input logic br, input logic rv, input int rt,
                        input logic rm, input logic cv, input int cold);
        @(negedge clk);
        ren_valid = v; ren_src1 = 5'(s1); ren_src2 = 5'(s2);
        ren_has_dst = hd; ren_dst = 5'(d); ren_is_branch = br;
        rsv_valid = rv; rsv_tag = 2'(rt); rsv_mispredict = rm;
        cmt_valid = cv; cmt_old_pdst = 6'(cold);
        #1;
    endtask

    task automatic idle();
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        ren_valid = 0; rsv_valid = 0; cmt_valid = 0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #(200000 * 8);
        errs++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        do_reset();
        // R1: identity mapping after reset
        step(1, 7, 20, 0, 0, 0, 0, 0, 0, 0, 0);
        chk("R1 reset psrc1", out_psrc1, 7);
        chk("R1 reset psrc2", out_psrc2, 20);
        chk("R1 reset ready", ren_ready, 1);
        chk("R7 reset mask", out_mask, 0);

        // Vector table: R1 R2 R3
        do_reset();
        foreach (VEC[i]) begin
            step(1, VEC[i][39:35], VEC[i][34:30], VEC[i][29], VEC[i][28:24], 0, 0, 0, 0, 0, 0);
            chk("R2 psrc1", out_psrc1, VEC[i][23:18]);
            chk("R2 psrc2", out_psrc2, VEC[i][17:12]);
            if (VEC[i][29]) begin
                chk("R1 pdst", out_pdst, VEC[i][11:6]);
                chk("R3 old", out_old_pdst, VEC[i][5:0]);
            end
        end
        idle();

        // R4 empty pool, R5 return order
        do_reset();
        for (int i = 0; i < 32; i++) begin
            step(1, 0, 0, 1, 1, 0, 0, 0, 0, 0, 0);
            chk("R1 pool walk", out_pdst, 32 + i);
        end
        step(1, 0, 0, 1, 2, 0, 0, 0, 0, 0, 0);
        chk("R4 empty ready", ren_ready, 0);
        chk("R4 empty valid", out_valid, 0);
        step(1, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        chk("R4 no-dst proceeds", out_valid, 1);
        chk("R4 no-dst src", out_psrc1, 63);
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 1);
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 32);
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 40);
        step(1, 0, 0, 1, 2, 0, 0, 0, 0, 0, 0);
        chk("R5 first returned", out_pdst, 1);
        step(1, 0, 0, 1, 2, 0, 0, 0, 0, 0, 0);
        chk("R5 second returned", out_pdst, 32);
        step(1, 0, 0, 1, 2, 0, 0, 0, 0, 0, 0);
        chk("R5 third returned", out_pdst, 40);
        chk("R3 old after reuse", out_old_pdst, 32);
        idle();

        // R6 R7 R8 slots and masks
        do_reset();
        step(1, 0, 0, 0, 0, 1, 0, 0, 0, 0, 0);
        chk("R6 first tag", out_br_tag, 0);
        chk("R7 first mask", out_mask, 0);
        step(1, 0, 0, 1, 2, 0, 0, 0, 0, 0, 0);
        chk("R7 dep mask", out_mask, 4'b0001);
        step(1, 0, 0, 0, 0, 1, 0, 0, 0, 0, 0);
        chk("R6 second tag", out_br_tag, 1);
        step(1, 0, 0, 0, 0, 1, 0, 0, 0, 0, 0);
        chk("R6 third tag", out_br_tag, 2);
        chk("R7 third mask", out_mask, 4'b0011);
        step(1, 0, 0, 0, 0, 1, 0, 0, 0, 0, 0);
        chk("R6 fourth tag", out_br_tag, 3);
        chk("R7 fourth mask", out_mask, 4'b0111);
        step(1, 0, 0, 0, 0, 1, 0, 0, 0, 0, 0);
        chk("R6 fifth stalls", ren_ready, 0);
        step(1, 0, 0, 0, 0, 0, 1, 1, 0, 0, 0);
        chk("R7 same-cycle resolve mask", out_mask, 4'b1101);
        step(1, 0, 0, 0, 0, 1, 0, 0, 0, 0, 0);
        chk("R8 freed slot ready", ren_ready, 1);
        chk("R8 freed slot tag", out_br_tag, 1);
        chk("R7 mask after resolve", out_mask, 4'b1101);
        idle();

        // R9 R10 R11 R12 mispredict
        do_reset();
        step(1, 0, 0, 0, 0, 1, 0, 0, 0, 0, 0);
        step(1, 0, 0, 1, 3, 0, 0, 0, 0, 0, 0);
        chk("R1 pdst before B", out_pdst, 32);
        step(1, 0, 0, 0, 0, 1, 0, 0, 0, 0, 0);
        chk("R6 B tag", out_br_tag, 1);
        step(1, 0, 0, 1, 3, 0, 0, 0, 0, 0, 0);
        chk("R3 old under B", out_old_pdst, 32);
        step(1, 0, 0, 0, 0, 1, 0, 0, 0, 0, 0);
        chk("R6 C tag", out_br_tag, 2);
        step(1, 0, 0, 1, 3, 0, 0, 0, 0, 0, 0);
        chk("R7 mask under C", out_mask, 4'b0111);
        step(1, 0, 0, 0, 0, 0, 1, 1, 1, 0, 0);
        chk("R11 squash ready", ren_ready, 0);
        chk("R11 squash valid", out_valid, 0);
        step(1, 3, 0, 1, 6, 0, 0, 0, 0, 0, 0);
        chk("R9 restored map", out_psrc1, 32);
        chk("R9 rewound pool", out_pdst, 33);
        chk("R10 older kept younger dropped", out_mask, 4'b0001);
        step(0, 0, 0, 0, 0, 0, 1, 3, 1, 0, 0);
        step(1, 6, 3, 0, 0, 0, 0, 0, 0, 0, 0);
        chk("R12 map untouched a", out_psrc1, 33);
        chk("R12 map untouched b", out_psrc2, 32);
        chk("R12 mask untouched", out_mask, 4'b0001);
        step(0, 0, 0, 0, 0, 0, 1, 2, 0, 0, 0);
        step(1, 0, 0, 1, 7, 1, 0, 0, 0, 0, 0);
        chk("R12 slot reuse tag", out_br_tag, 1);
        chk("R12 pool untouched", out_pdst, 34);
        chk("R10 mask after squash", out_mask, 4'b0001);
        idle();

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule